// File: doc/BRIEF.md
# Quasi-Cyclic Convolution Systolic Array

This block computes a length-4 quasi-cyclic convolution. That is a matrix-vector product in which every diagonal of the matrix carries one constant magnitude, and each entry on a diagonal may take either sign. Four identical processing elements sit in a closed ring. Each element holds one fixed coefficient and multiplies by it using only shifts and adds, in canonical signed-digit form. A per-element sign tag selects whether the product is added to the partial sum passing through that element or subtracted from it. Partial sums are registered between elements and move one element round the ring with each accepted operand.

A frame is four operands q0..q3. They arrive one per `in_valid` cycle, in the order the frame defines. The array broadcasts each operand to all elements. A small tag sequencer derives each element's sign tag from the operand's position in the frame and the sign-pattern parameter. When the fourth operand is accepted, the four finished row sums are captured into an output shift register. They then leave one per cycle, each marked by a strobe and a row index. The next frame accumulates in the ring while the previous results drain, so frames may follow one another with no gap. The coefficients, the sign pattern and the data width are parameters.

Top module: `qcyc_conv_array`

## Requirements
- R1: Reset (asynchronous, active low) clears all state. Afterwards `out_valid`, `out_idx` and `out_data` read zero, and any operands of an unfinished frame are discarded, so the next four accepted operands form a fresh frame.
- R2: An operand is accepted only in a cycle with `in_valid` high. Every fourth accepted operand completes a frame, and cycles with `in_valid` low may fall between the operands of a frame without changing its results.
- R3: Row k (k = 0..3) of a frame equals the sum over j = 0..3 of s·COEF[j]·q[(j−k) mod 4]. Here q[t] is the t-th accepted operand, taken as signed two's complement. The sign s is −1 when bit k·4+j of SIGN_PAT is 1 and +1 otherwise. The default coefficients are 127, 81, 13 and 100, and the default SIGN_PAT 16'h7310 negates exactly the terms with j < k.
- R4: In the cycle after the clock edge that accepts the fourth operand, `out_valid` rises. It stays high for exactly four cycles, and `out_idx` reads 0, 1, 2, 3 in order while `out_data` carries the matching row.
- R5: Frames delivered back to back, one operand per cycle, produce an unbroken stream of results with `out_valid` high in every cycle and no row lost.
- R6: While `out_valid` is low, `out_data` and `out_idx` are both zero.
- R7: Results are exact at full width (17 bits signed for the defaults) for extreme operands. Four operands of −128 give −41088 in row 0, and four operands of 127 give 40767 in row 0.
- R8: The value on `in_data` in a cycle with `in_valid` low has no effect on any result, and the partial sums and frame position hold through such cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 8 | Signed operand |
| out_valid | output | 1 | Result strobe |
| out_idx | output | 2 | Row number of the result on `out_data` |
| out_data | output | 17 | Signed row result |

## Verification
The hardest case to reach from the ports is a frame whose operands are spread out by idle cycles while junk values sit on `in_data`. Only a correct hold of both the rotating partial sums and the frame position gives the same four rows as a frame delivered without gaps. The stimulus interleaves idle cycles of several lengths, carrying extreme junk values, between the operands of a frame. It compares every row against the formula. It also runs frames back to back and checks that no gap opens in the output stream. A reset in the middle of a frame, followed by a fresh frame, shows that the stale partial operands are dropped.

// File: rtl/qcc_pkg.sv
package qcc_pkg;

  // Positions of +1 digits in the canonical signed-digit form of c.
  function automatic logic [31:0] csd_plus(input int c);
    int r;
    logic [31:0] m;
    r = c;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (r[0]) begin
        if (!r[1]) begin
          m[i] = 1'b1;
          r = r - 1;
        end else begin
          r = r + 1;
        end
      end
      r = r >>> 1;
    end
    return m;
  endfunction

  // Positions of -1 digits in the canonical signed-digit form of c.
  function automatic logic [31:0] csd_minus(input int c);
    int r;
    logic [31:0] m;
    r = c;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (r[0]) begin
        if (r[1]) begin
          m[i] = 1'b1;
          r = r + 1;
        end else begin
          r = r - 1;
        end
      end
      r = r >>> 1;
    end
    return m;
  endfunction

  // Row handled by element j when operand number t of a frame is broadcast.
  function automatic int ring_row(input int j, input int t, input int n);
    return ((j - t) % n + n) % n;
  endfunction

endpackage

// File: rtl/qcc_tag_seq.sv
module qcc_tag_seq
  import qcc_pkg::*;
#(
  parameter int N = 4,
  parameter logic [N*N-1:0] PAT = '0,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [IW-1:0] beat,
  output logic          last,
  output logic [N-1:0]  tags
);

  logic at_end;
  assign at_end = (beat == IW'(N - 1));
  assign last   = in_valid & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat <= '0;
    end else if (in_valid) begin
      beat <= at_end ? '0 : beat + 1'b1;
    end
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      tags[j] = PAT[ring_row(j, int'(beat), N) * N + j];
    end
  end

  p_beat_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && beat == IW'(N - 1)) |=> (beat == '0));

  p_beat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && beat != IW'(N - 1)) |=> (beat == $past(beat) + 1'b1));

  p_beat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(beat));

endmodule

// File: rtl/qcc_pe.sv
module qcc_pe
  import qcc_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 17,
  parameter int CSD_W = 8,
  parameter int unsigned COEF = 1,
  localparam logic [31:0] PLUS  = csd_plus(int'(COEF)),
  localparam logic [31:0] MINUS = csd_minus(int'(COEF))
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic                 tag,
  input  logic signed [DW-1:0] x,
  input  logic signed [SW-1:0] psum_in,
  output logic signed [SW-1:0] sum_out,
  output logic signed [SW-1:0] psum_q
);

  logic signed [SW-1:0] xe;
  logic signed [SW-1:0] prod;
  logic signed [SW-1:0] base;

  assign xe = SW'(x);

  // Constant multiply: shifts and adds chosen by the signed-digit masks.
  always_comb begin
    prod = '0;
    for (int b = 0; b < CSD_W; b++) begin
      if (PLUS[b]) begin
        prod = prod + (xe <<< b);
      end else if (MINUS[b]) begin
        prod = prod - (xe <<< b);
      end
    end
  end

  assign base    = clr ? '0 : psum_in;
  assign sum_out = tag ? (base - prod) : (base + prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psum_q <= '0;
    end else if (en) begin
      psum_q <= sum_out;
    end
  end

  p_psum_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(psum_q));

endmodule

// File: rtl/qcc_out_sr.sv
module qcc_out_sr #(
  parameter int N = 4,
  parameter int SW = 17,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [N-1:0][SW-1:0]  load_vec,
  output logic                  out_valid,
  output logic [IW-1:0]         out_idx,
  output logic [SW-1:0]         out_data
);

  logic [N-1:0][SW-1:0] sr;
  logic [CW-1:0]        cnt;
  logic                 shift_evt;

  assign shift_evt = !load && (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      cnt     <= '0;
      out_idx <= '0;
    end else if (load) begin
      sr      <= load_vec;
      cnt     <= CW'(N);
      out_idx <= '0;
    end else if (shift_evt) begin
      for (int i = 0; i < N - 1; i++) begin
        sr[i] <= sr[i + 1];
      end
      sr[N-1] <= '0;
      cnt     <= cnt - 1'b1;
      out_idx <= (cnt == CW'(1)) ? '0 : out_idx + 1'b1;
    end
  end

  assign out_valid = (cnt != '0);
  assign out_data  = sr[0];

  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (out_valid && out_idx == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load && out_idx != IW'(N - 1)) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1));

  p_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !load && out_idx == IW'(N - 1)) |=> !out_valid);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0 && out_idx == '0));

endmodule

// File: rtl/qcyc_conv_array.sv
module qcyc_conv_array #(
  parameter int DW = 8,
  parameter int N = 4,
  parameter int COEF_W = 7,
  parameter int unsigned COEF [N] = '{127, 81, 13, 100},
  parameter logic [N*N-1:0] SIGN_PAT = 16'h7310,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = DW + COEF_W + $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [SW-1:0] out_data
);

  logic [IW-1:0]        beat;
  logic                 frame_done;
  logic                 clr_acc;
  logic [N-1:0]         tags;
  logic [N-1:0][SW-1:0] psum_q;
  logic [N-1:0][SW-1:0] sum_c;
  logic [N-1:0][SW-1:0] cap_vec;

  qcc_tag_seq #(
    .N   (N),
    .PAT (SIGN_PAT)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .beat     (beat),
    .last     (frame_done),
    .tags     (tags)
  );

  // The first operand of a frame starts every row from zero.
  assign clr_acc = (beat == '0);

  for (genvar j = 0; j < N; j++) begin : g_pe
    qcc_pe #(
      .DW    (DW),
      .SW    (SW),
      .CSD_W (COEF_W + 1),
      .COEF  (COEF[j])
    ) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_valid),
      .clr     (clr_acc),
      .tag     (tags[j]),
      .x       (in_data),
      .psum_in (psum_q[(j + N - 1) % N]),
      .sum_out (sum_c[j]),
      .psum_q  (psum_q[j])
    );
    // Row j is finished by the element N-1 places further round the ring.
    assign cap_vec[j] = sum_c[(j + N - 1) % N];
  end

  qcc_out_sr #(
    .N  (N),
    .SW (SW)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_done),
    .load_vec  (cap_vec),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_data  (out_data)
  );

  p_frame_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_valid);

endmodule

// File: tb/sim_qcyc_conv_array.sv
`timescale 1ns/1ps
module sim_qcyc_conv_array;

  localparam int DW = 8;
  localparam int IW = 2;
  localparam int SW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [IW-1:0] out_idx;
  logic [SW-1:0] out_data;

  always #4 clk = ~clk;

  qcyc_conv_array u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_idx   (out_idx),
    .out_data  (out_data)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  bit    cmp_en = 1'b0;
  string cur_req = "R1";
  int    coef [4] = '{127, 81, 13, 100};

  // Reference model state.
  int q [4];
  int nq = 0;
  int rows [4];
  int m_rem = 0;
  int m_idx = 0;
  int run = 0;
  int maxrun = 0;
  int got [4];

  // Row k: terms whose element index is below the row index are negated.
  function automatic int ref_row(input int qq [4], input int k);
    int s;
    s = 0;
    for (int j = 0; j < 4; j++) begin
      int term;
      term = coef[j] * qq[(j - k + 4) % 4];
      if (j < k) s = s - term;
      else       s = s + term;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      nq = 0;
      m_rem = 0;
      m_idx = 0;
    end else begin
      if (m_rem > 0) begin
        m_rem--;
        m_idx = (m_rem == 0) ? 0 : m_idx + 1;
      end
      if (in_valid) begin
        q[nq] = int'($signed(in_data));
        nq++;
        if (nq == 4) begin
          for (int k = 0; k < 4; k++) rows[k] = ref_row(q, k);
          m_rem = 4;
          m_idx = 0;
          nq = 0;
        end
      end
    end
  end

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      bit ev;
      int eidx;
      int ed;
      int ad;
      ev   = (m_rem > 0);
      eidx = ev ? m_idx : 0;
      ed   = ev ? rows[m_idx] : 0;
      ad   = int'($signed(out_data));
      checks++;
      if (out_valid !== ev || int'(out_idx) != eidx || ad != ed) begin
        fails++;
        $display("FAIL %s (%s): valid/idx/data got %0d/%0d/%0d expected %0d/%0d/%0d",
                 (out_valid !== ev || int'(out_idx) != eidx) ? "R4" : (ev ? "R3" : "R6"),
                 cur_req, out_valid, out_idx, ad, ev, eidx, ed);
      end
      if (out_valid) begin
        run++;
        if (run > maxrun) maxrun = run;
      end else begin
        run = 0;
      end
    end
  end

  task automatic feed(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(v);
  endtask

  task automatic idle(input int n, input int junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = DW'(junk);
    end
  endtask

  // Feeds one frame without gaps and checks the four rows as they leave.
  task automatic frame_check(input int a, input int b, input int c, input int d,
                             input string req);
    int qq [4];
    qq = '{a, b, c, d};
    feed(a); feed(b); feed(c); feed(d);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = '0;
      got[k] = int'($signed(out_data));
      check(out_valid === 1'b1 && int'(out_idx) == k, req, "row strobe/index",
            int'(out_idx), k);
      check(got[k] == ref_row(qq, k), req, "row value", got[k], ref_row(qq, k));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    cmp_en = 1'b1;
    @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_idx == '0 && out_data == '0, "R1",
          "outputs after reset", int'(out_data), 0);

    // R3 and R4: main function, several patterns
    cur_req = "R3";
    frame_check(1, 2, 3, 4, "R3");
    idle(3, 0);
    frame_check(10, -20, 30, -40, "R3");
    idle(2, 0);
    frame_check(0, 0, 1, 0, "R4");
    idle(5, 0);
    check(out_valid === 1'b0 && out_data == '0 && out_idx == '0, "R6",
          "idle outputs", int'(out_data), 0);
    for (int f = 0; f < 8; f++) begin
      int r [4];
      for (int i = 0; i < 4; i++) r[i] = $urandom_range(255) - 128;
      frame_check(r[0], r[1], r[2], r[3], "R3");
      idle(f % 3, 0);
    end
    idle(4, 0);

    // R7: extreme operands, exact at full width
    cur_req = "R7";
    frame_check(-128, -128, -128, -128, "R7");
    check(got[0] == -41088, "R7", "row 0 all -128", got[0], -41088);
    check(got[3] == 15488, "R7", "row 3 all -128", got[3], 15488);
    idle(2, 0);
    frame_check(127, 127, 127, 127, "R7");
    check(got[0] == 40767, "R7", "row 0 all 127", got[0], 40767);
    idle(4, 0);

    // R5: back-to-back frames
    cur_req = "R5";
    maxrun = 0;
    for (int f = 0; f < 3; f++) begin
      feed(5 * f + 1); feed(-7); feed(100 - f); feed(-128 + f);
    end
    idle(8, 0);
    check(maxrun == 12, "R5", "continuous valid cycles", maxrun, 12);

    // R2 and R8: gaps inside a frame with junk on the data input
    cur_req = "R8";
    begin
      int qq [4];
      qq = '{33, -77, 120, -5};
      feed(33);  idle(2, 127);
      feed(-77); idle(1, -1);
      feed(120); idle(3, -128);
      feed(-5);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 8'h55;
        check(out_valid === 1'b1 && int'($signed(out_data)) == ref_row(qq, k),
              "R2", "row with gapped operands", int'($signed(out_data)), ref_row(qq, k));
      end
      idle(3, 99);
      check(out_valid === 1'b0, "R8", "no output from junk", int'(out_valid), 0);
    end

    // R1: reset in the middle of a frame discards partial operands
    cur_req = "R1";
    feed(50); feed(60);
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data == '0, "R1", "after mid-frame reset",
          int'(out_valid), 0);
    frame_check(-3, 9, -27, 81, "R1");
    idle(4, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule